// File: doc/BRIEF.md
# Predicated Indexed Vector Load Sequencer

This block steps through the elements of an indexed vector load. Every element's effective address is the sum of two register operands, a base and an offset. The base, the offset and the destination are each flagged independently as a vector or as a scalar. A vector operand walks through consecutive register numbers, and a scalar operand stays on its one register. Predicate masks select which element positions take part.

A start strobe captures a vector length, two predicate masks, three vector flags and three register numbers. The block then reads the base and offset registers through two combinational register-file read ports and forms the address. It sends one read over a valid/ready request channel and waits for the matching response. It writes the returned data to the destination register. It repeats this until an element counter runs out, and then pulses done.

Top module: `vidx_load_seq`

## Requirements
- R1: Each memory request address equals the base register value plus the offset register value, wrapping modulo 2^64. The request stays valid with a stable address until it is accepted.
- R2: A vector base is read from base register number plus counter i, and a vector offset from offset register number plus counter k. A scalar base or offset always reads its own register number.
- R3: Each response is written back once, with its data unchanged. The destination is register number plus counter j for a vector destination, or the fixed destination register for a scalar one.
- R4: Predicate bit n governs element n. A vector base skips positions whose source-mask bit is 0, and so does a vector offset. A vector destination skips positions whose destination-mask bit is 0.
- R5: After each element, a counter advances by one only if its operand is a vector. A scalar operand's counter stays at 0.
- R6: Elements are processed while i, j and k are all below VL. If a skip takes any counter to VL or beyond, the run ends with no further request. VL of 0 issues no request.
- R7: When all three flags are scalar (0) and VL is nonzero, exactly one load is performed and the run ends.
- R8: At most one request is outstanding. No new request is raised until the previous response has been taken.
- R9: Each accepted start produces exactly one single-cycle done pulse at the end of its run. Busy is high from the cycle after the start until done.
- R10: A start while busy is ignored, and the run in progress completes with its original configuration.
- R11: After reset the block is idle: busy, done, request valid and write enable are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| vl_i | input | CW | Vector length, 0 to NE |
| src_mask_i | input | NE | Source predicate, bit n for element n |
| dst_mask_i | input | NE | Destination predicate, bit n for element n |
| base_vec_i | input | 1 | 1 = base is a vector |
| ofs_vec_i | input | 1 | 1 = offset is a vector |
| dst_vec_i | input | 1 | 1 = destination is a vector |
| base_reg_i | input | RW | Base register number |
| ofs_reg_i | input | RW | Offset register number |
| dst_reg_i | input | RW | Destination register number |
| rfa_addr_o | output | RW | Read port A register number (base) |
| rfa_data_i | input | XLEN | Read port A data |
| rfb_addr_o | output | RW | Read port B register number (offset) |
| rfb_data_i | input | XLEN | Read port B data |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | XLEN | Read request address |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_data_i | input | XLEN | Read response data |
| wb_en_o | output | 1 | Register write enable |
| wb_addr_o | output | RW | Register write number |
| wb_data_o | output | XLEN | Register write data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the block with its defaults: eight element positions, 5-bit register numbers and 64-bit data. With eight positions, a full-length run over all-ones masks is affordable, and so are masks whose only set bits lie at or above VL. The 32-register space reaches register 31, and the bench gives that register an all-ones value, so the address sum wraps.

// File: rtl/vls_pkg.sv
// Package: shared state encoding and lane indices for the indexed load sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package vls_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SKIP = 3'd1,
        ST_READ = 3'd2,
        ST_REQ  = 3'd3,
        ST_WAIT = 3'd4,
        ST_FIN  = 3'd5
    } vls_state_e;

    // Lane numbering for the three element counters
    localparam int LANE_BASE = 0;
    localparam int LANE_OFS  = 1;
    localparam int LANE_DST  = 2;
    localparam int NLANE     = 3;

endpackage

// File: rtl/vls_skip_scan.sv
// Module: finds the first enabled predicate position at or above a start index.
// Assumes: for a scalar lane the start index passes through unchanged; when no
// enabled position remains, the result is NE, which lies at or beyond any legal VL.
module vls_skip_scan #(
    parameter int NE = 8,
    parameter int CW = $clog2(NE + 1)
) (
    input  logic [NE-1:0] mask_i,
    input  logic [CW-1:0] from_i,
    input  logic          is_vec_i,
    output logic [CW-1:0] pos_o
);
    // Priority search from the top down so that the lowest match wins
    always_comb begin
        pos_o = is_vec_i ? CW'(NE) : from_i;
        if (is_vec_i) begin
            for (int b = NE - 1; b >= 0; b--) begin
                if (mask_i[b] && (CW'(b) >= from_i)) pos_o = CW'(b);
            end
        end
    end
endmodule

// File: rtl/vls_elem_ctr.sv
// Module: one element counter with predicate skipping (base, offset or destination).
// Assumes: clear, skip and step are mutually exclusive strobes from the sequencer;
// step is issued only for an element that lay below VL.
module vls_elem_ctr #(
    parameter int NE = 8,
    parameter int CW = $clog2(NE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          skip_i,
    input  logic          step_i,
    input  logic          is_vec_i,
    input  logic [NE-1:0] mask_i,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] skip_pos;

    vls_skip_scan #(.NE(NE), .CW(CW)) u_scan (
        .mask_i  (mask_i),
        .from_i  (cnt_q),
        .is_vec_i(is_vec_i),
        .pos_o   (skip_pos)
    );

    // Counter update: clear on start, jump on skip, advance on vector step
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (clear_i)         cnt_q <= '0;
        else if (skip_i)          cnt_q <= skip_pos;
        else if (step_i && is_vec_i) cnt_q <= cnt_q + CW'(1);
    end

    assign cnt_o = cnt_q;

    // R5: a scalar lane never leaves position 0
    a_r5_scalar_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !is_vec_i |-> (cnt_q == '0));

    // R6: a step only follows an element that lay inside the mask range
    a_r6_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (cnt_q < CW'(NE)));
endmodule

// File: rtl/vls_operand_path.sv
// Module: register-number generation for both read ports and the write port,
// plus the effective-address register.
// Assumes: the register file reads combinationally in the same cycle.
module vls_operand_path #(
    parameter int XLEN = 64,
    parameter int RW   = 5,
    parameter int CW   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture_i,
    input  logic [RW-1:0]   base_reg_i,
    input  logic [RW-1:0]   ofs_reg_i,
    input  logic [RW-1:0]   dst_reg_i,
    input  logic            base_vec_i,
    input  logic            ofs_vec_i,
    input  logic            dst_vec_i,
    input  logic [CW-1:0]   cnt_i_i,
    input  logic [CW-1:0]   cnt_k_i,
    input  logic [CW-1:0]   cnt_j_i,
    input  logic [XLEN-1:0] rfa_data_i,
    input  logic [XLEN-1:0] rfb_data_i,
    output logic [RW-1:0]   rfa_addr_o,
    output logic [RW-1:0]   rfb_addr_o,
    output logic [RW-1:0]   wb_idx_o,
    output logic [XLEN-1:0] ea_o
);
    logic [XLEN-1:0] ea_q;

    // Vector operands offset their register number by their counter
    always_comb begin
        rfa_addr_o = base_vec_i ? (base_reg_i + RW'(cnt_i_i)) : base_reg_i;
        rfb_addr_o = ofs_vec_i  ? (ofs_reg_i  + RW'(cnt_k_i)) : ofs_reg_i;
        wb_idx_o   = dst_vec_i  ? (dst_reg_i  + RW'(cnt_j_i)) : dst_reg_i;
    end

    // Effective address: wrapping sum of the two operands, held for the request
    always_ff @(posedge clk) begin
        if (!rst_n)         ea_q <= '0;
        else if (capture_i) ea_q <= rfa_data_i + rfb_data_i;
    end

    assign ea_o = ea_q;
endmodule

// File: rtl/vidx_load_seq.sv
// Module: top of the predicated indexed vector load sequencer.
// Assumes: vl_i never exceeds NE; memory returns exactly one response per
// accepted request; register file reads are combinational.
module vidx_load_seq
    import vls_pkg::*;
#(
    parameter int NE   = 8,
    parameter int RW   = 5,
    parameter int XLEN = 64,
    localparam int CW  = $clog2(NE + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [CW-1:0]   vl_i,
    input  logic [NE-1:0]   src_mask_i,
    input  logic [NE-1:0]   dst_mask_i,
    input  logic            base_vec_i,
    input  logic            ofs_vec_i,
    input  logic            dst_vec_i,
    input  logic [RW-1:0]   base_reg_i,
    input  logic [RW-1:0]   ofs_reg_i,
    input  logic [RW-1:0]   dst_reg_i,
    output logic [RW-1:0]   rfa_addr_o,
    input  logic [XLEN-1:0] rfa_data_i,
    output logic [RW-1:0]   rfb_addr_o,
    input  logic [XLEN-1:0] rfb_data_i,
    output logic            mem_req_valid_o,
    input  logic            mem_req_ready_i,
    output logic [XLEN-1:0] mem_req_addr_o,
    input  logic            mem_rsp_valid_i,
    input  logic [XLEN-1:0] mem_rsp_data_i,
    output logic            wb_en_o,
    output logic [RW-1:0]   wb_addr_o,
    output logic [XLEN-1:0] wb_data_o,
    output logic            busy_o,
    output logic            done_o
);
    vls_state_e      state_q, state_d;
    logic [CW-1:0]   vl_q;
    logic [NE-1:0]   smask_q, dmask_q;
    logic [NLANE-1:0] vec_q;
    logic [RW-1:0]   base_reg_q, ofs_reg_q, dst_reg_q;
    logic            wb_en_q;
    logic [RW-1:0]   wb_addr_q;
    logic [XLEN-1:0] wb_data_q;

    logic            take_start, do_skip, do_step, do_capture, out_of_range, all_scalar;
    logic [NE-1:0]   lane_mask [NLANE];
    logic [CW-1:0]   lane_cnt  [NLANE];
    logic [RW-1:0]   wb_idx;
    logic [XLEN-1:0] ea;

    assign take_start = (state_q == ST_IDLE) && start_i;
    assign do_skip    = (state_q == ST_SKIP);
    assign do_step    = (state_q == ST_WAIT) && mem_rsp_valid_i;
    assign all_scalar = (vec_q == '0);

    // Any counter at or past VL ends the run
    always_comb begin
        out_of_range = 1'b0;
        for (int l = 0; l < NLANE; l++) begin
            if (lane_cnt[l] >= vl_q) out_of_range = 1'b1;
        end
    end
    assign do_capture = (state_q == ST_READ) && !out_of_range;

    // Lane predicate selection: base and offset follow the source mask
    assign lane_mask[LANE_BASE] = smask_q;
    assign lane_mask[LANE_OFS]  = smask_q;
    assign lane_mask[LANE_DST]  = dmask_q;

    // One counter per lane
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        vls_elem_ctr #(.NE(NE), .CW(CW)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (take_start),
            .skip_i  (do_skip),
            .step_i  (do_step),
            .is_vec_i(vec_q[l]),
            .mask_i  (lane_mask[l]),
            .cnt_o   (lane_cnt[l])
        );
    end

    vls_operand_path #(.XLEN(XLEN), .RW(RW), .CW(CW)) u_opnd (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (do_capture),
        .base_reg_i(base_reg_q),
        .ofs_reg_i (ofs_reg_q),
        .dst_reg_i (dst_reg_q),
        .base_vec_i(vec_q[LANE_BASE]),
        .ofs_vec_i (vec_q[LANE_OFS]),
        .dst_vec_i (vec_q[LANE_DST]),
        .cnt_i_i   (lane_cnt[LANE_BASE]),
        .cnt_k_i   (lane_cnt[LANE_OFS]),
        .cnt_j_i   (lane_cnt[LANE_DST]),
        .rfa_data_i(rfa_data_i),
        .rfb_data_i(rfb_data_i),
        .rfa_addr_o(rfa_addr_o),
        .rfb_addr_o(rfb_addr_o),
        .wb_idx_o  (wb_idx),
        .ea_o      (ea)
    );

    // Configuration capture on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q <= '0; smask_q <= '0; dmask_q <= '0; vec_q <= '0;
            base_reg_q <= '0; ofs_reg_q <= '0; dst_reg_q <= '0;
        end else if (take_start) begin
            vl_q       <= vl_i;
            smask_q    <= src_mask_i;
            dmask_q    <= dst_mask_i;
            vec_q      <= {dst_vec_i, ofs_vec_i, base_vec_i};
            base_reg_q <= base_reg_i;
            ofs_reg_q  <= ofs_reg_i;
            dst_reg_q  <= dst_reg_i;
        end
    end

    // Next-state logic of the element sequencer
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_SKIP;
            ST_SKIP: state_d = ST_READ;
            ST_READ: state_d = out_of_range ? ST_FIN : ST_REQ;
            ST_REQ:  if (mem_req_ready_i) state_d = ST_WAIT;
            ST_WAIT: if (mem_rsp_valid_i) state_d = all_scalar ? ST_FIN : ST_SKIP;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered write-back of each response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_en_q <= 1'b0; wb_addr_q <= '0; wb_data_q <= '0;
        end else begin
            wb_en_q <= do_step;
            if (do_step) begin
                wb_addr_q <= wb_idx;
                wb_data_q <= mem_rsp_data_i;
            end
        end
    end

    assign mem_req_valid_o = (state_q == ST_REQ);
    assign mem_req_addr_o  = ea;
    assign wb_en_o         = wb_en_q;
    assign wb_addr_o       = wb_addr_q;
    assign wb_data_o       = wb_data_q;
    assign busy_o          = (state_q != ST_IDLE);
    assign done_o          = (state_q == ST_FIN);

    // R1: a pending request keeps its valid and address
    a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

    // R8: an accepted request is not followed at once by another
    a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && mem_req_ready_i |=> !mem_req_valid_o);

    // R7: in an all-scalar run the write-back coincides with the end
    a_r7_scalar_single: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o && all_scalar |-> done_o);

    // R9: done lasts exactly one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: a start while busy leaves the captured configuration alone
    a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> $stable(dst_reg_q) && $stable(vl_q) && $stable(vec_q));

    // R11: an idle block issues no request
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_valid_o);
endmodule

// File: tb/vidx_load_seq_test.sv
// Bench: table-driven runs against a requirement-level reference loop, then
// directed tests for reset and a start while busy.
module vidx_load_seq_test;
    localparam int NE = 8, RW = 5, XLEN = 64, CW = $clog2(NE + 1);

    typedef struct packed {
        logic [3:0] vl;
        logic [7:0] sm;
        logic [7:0] dm;
        logic       bv, ov, dv;
        logic [4:0] br, ofr, dr;
        logic [4:0] nexp;
    } vec_t;

    // vl, smask, dmask, bvec, ovec, dvec, breg, oreg, dreg, expected loads
    localparam vec_t TBL [12] = '{
        '{4'd4, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 5'd2,  5'd3,  5'd5,  5'd1},
        '{4'd4, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 5'd2,  5'd10, 5'd20, 5'd4},
        '{4'd5, 8'h16, 8'h00, 1'b1, 1'b0, 1'b0, 5'd8,  5'd4,  5'd1,  5'd3},
        '{4'd4, 8'h00, 8'h0A, 1'b0, 1'b0, 1'b1, 5'd6,  5'd7,  5'd12, 5'd2},
        '{4'd4, 8'h07, 8'h0C, 1'b1, 1'b0, 1'b1, 5'd3,  5'd9,  5'd16, 5'd2},
        '{4'd0, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, 5'd2,  5'd3,  5'd5,  5'd0},
        '{4'd8, 8'h00, 8'hFF, 1'b1, 1'b0, 1'b0, 5'd2,  5'd3,  5'd5,  5'd0},
        '{4'd4, 8'h09, 8'h00, 1'b0, 1'b1, 1'b0, 5'd11, 5'd14, 5'd0,  5'd2},
        '{4'd8, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 5'd0,  5'd8,  5'd16, 5'd8},
        '{4'd1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 5'd31, 5'd1,  5'd4,  5'd1},
        '{4'd6, 8'h25, 8'h00, 1'b1, 1'b1, 1'b0, 5'd1,  5'd20, 5'd30, 5'd3},
        '{4'd3, 8'h18, 8'h00, 1'b1, 1'b0, 1'b0, 5'd2,  5'd3,  5'd5,  5'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [CW-1:0] vl = '0;
    logic [NE-1:0] smask = '0, dmask = '0;
    logic bvec = 1'b0, ovec = 1'b0, dvec = 1'b0;
    logic [RW-1:0] breg = '0, oreg = '0, dreg = '0;
    logic [RW-1:0] rfa_addr, rfb_addr, wb_addr;
    logic [XLEN-1:0] rfa_data, rfb_data, req_addr, wb_data;
    logic req_valid, req_ready = 1'b0, rsp_valid = 1'b0, wb_en, busy, done;
    logic [XLEN-1:0] rsp_data = '0;

    int checks = 0, errors = 0, cycles = 0;
    int n_req = 0, n_wb = 0, n_done = 0, viol = 0;
    logic [XLEN-1:0] got_a [16];
    logic [RW-1:0]   got_wa [16];
    logic [XLEN-1:0] got_wd [16];
    logic [XLEN-1:0] exp_a [16];
    logic [RW-1:0]   exp_wa [16];
    logic [XLEN-1:0] exp_wd [16];
    int exp_n = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    function automatic logic [XLEN-1:0] rfval(input logic [RW-1:0] r);
        return (r == 5'd31) ? {XLEN{1'b1}} : (64'h1_0000_0000 + (64'(r) << 8));
    endfunction
    function automatic logic [XLEN-1:0] memval(input logic [XLEN-1:0] a);
        return a ^ 64'hC3C3_0000_0000_5A5A;
    endfunction

    assign rfa_data = rfval(rfa_addr);
    assign rfb_data = rfval(rfb_addr);

    vidx_load_seq #(.NE(NE), .RW(RW), .XLEN(XLEN)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .vl_i(vl),
        .src_mask_i(smask), .dst_mask_i(dmask),
        .base_vec_i(bvec), .ofs_vec_i(ovec), .dst_vec_i(dvec),
        .base_reg_i(breg), .ofs_reg_i(oreg), .dst_reg_i(dreg),
        .rfa_addr_o(rfa_addr), .rfa_data_i(rfa_data),
        .rfb_addr_o(rfb_addr), .rfb_data_i(rfb_data),
        .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready),
        .mem_req_addr_o(req_addr), .mem_rsp_valid_i(rsp_valid),
        .mem_rsp_data_i(rsp_data), .wb_en_o(wb_en), .wb_addr_o(wb_addr),
        .wb_data_o(wb_data), .busy_o(busy), .done_o(done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Memory responder and output monitor, all at the falling edge
    initial begin
        logic [XLEN-1:0] lat = '0;
        bit acc = 0;
        int gap = 0;
        forever begin
            @(negedge clk);
            if (wb_en && n_wb < 16) begin got_wa[n_wb] = wb_addr; got_wd[n_wb] = wb_data; end
            if (wb_en) n_wb++;
            if (done) n_done++;
            rsp_valid = 1'b0;
            if (acc) begin
                if (req_valid) viol++;           // R8: nothing new while one is outstanding
                if (gap > 0) gap--;
                else begin rsp_valid = 1'b1; rsp_data = memval(lat); acc = 0; end
            end else if (req_ready) begin
                req_ready = 1'b0; acc = 1; gap = n_req % 3;
            end else if (req_valid) begin
                lat = req_addr;
                if (n_req < 16) got_a[n_req] = req_addr;
                n_req++;
                req_ready = 1'b1;
            end
        end
    end

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                check(1'b0, "watchdog", 64'(cycles), 64'd100000);
                summary();
            end
        end
    end

    // Reference loop written from R2..R7
    task automatic model(input vec_t v);
        int i = 0, j = 0, k = 0;
        logic [XLEN-1:0] ea;
        exp_n = 0;
        forever begin
            if (v.bv) while (i < int'(v.vl) && !v.sm[i]) i++;
            if (v.ov) while (k < int'(v.vl) && !v.sm[k]) k++;
            if (v.dv) while (j < int'(v.vl) && !v.dm[j]) j++;
            if (i >= int'(v.vl) || j >= int'(v.vl) || k >= int'(v.vl)) break;
            ea = rfval(v.bv ? 5'(v.br + 5'(i)) : v.br) + rfval(v.ov ? 5'(v.ofr + 5'(k)) : v.ofr);
            exp_a[exp_n]  = ea;
            exp_wa[exp_n] = v.dv ? 5'(v.dr + 5'(j)) : v.dr;
            exp_wd[exp_n] = memval(ea);
            exp_n++;
            if (!v.bv && !v.ov && !v.dv) break;
            if (v.bv) i++;
            if (v.ov) k++;
            if (v.dv) j++;
        end
    endtask

    task automatic drive(input vec_t v);
        vl = v.vl; smask = v.sm; dmask = v.dm;
        bvec = v.bv; ovec = v.ov; dvec = v.dv;
        breg = v.br; oreg = v.ofr; dreg = v.dr;
    endtask

    // Launch one run, optionally poke a second start while busy, then compare
    task automatic run(input vec_t v, input bit poke, input vec_t other);
        n_req = 0; n_wb = 0; n_done = 0; viol = 0;
        model(v);
        @(negedge clk);
        drive(v); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            check(busy == 1'b1, "R9 busy during run", 64'(busy), 64'd1);
            drive(other); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int t = 0; t < 600 && n_done == 0; t++) @(posedge clk);
        repeat (6) @(negedge clk);
        check(n_done == 1, "R9 done pulses", 64'(n_done), 64'd1);
        check(n_req == int'(v.nexp), "R6/R7 load count", 64'(n_req), 64'(v.nexp));
        check(n_wb == exp_n, "R3 write count", 64'(n_wb), 64'(exp_n));
        check(viol == 0, "R8 single outstanding", 64'(viol), 64'd0);
        for (int e = 0; e < exp_n && e < n_req && e < n_wb; e++) begin
            // R2, R4 and R5 show in the address sequence
            check(got_a[e] == exp_a[e], "R1/R2/R4/R5 request address", got_a[e], exp_a[e]);
            check(got_wa[e] == exp_wa[e], "R3 write register", 64'(got_wa[e]), 64'(exp_wa[e]));
            check(got_wd[e] == exp_wd[e], "R3 write data", got_wd[e], exp_wd[e]);
        end
        check(busy == 1'b0, "R9 idle after done", 64'(busy), 64'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        check(busy == 1'b0, "R11 busy", 64'(busy), 64'd0);
        check(done == 1'b0, "R11 done", 64'(done), 64'd0);
        check(req_valid == 1'b0, "R11 request", 64'(req_valid), 64'd0);
        check(wb_en == 1'b0, "R11 write", 64'(wb_en), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int t = 0; t < 12; t++) run(TBL[t], 1'b0, TBL[0]);
        // R10: a start while busy is ignored; the first run finishes as configured
        run(TBL[1], 1'b1, TBL[0]);
        run(TBL[4], 1'b1, TBL[8]);
        // R6: nothing happens after a run ends without a new start
        n_req = 0;
        repeat (20) @(negedge clk);
        check(n_req == 0, "R6 no stray request", 64'(n_req), 64'd0);
        summary();
    end
endmodule